// File: doc/BRIEF.md
# Synchronized Low-Order Interleaved Memory

The memory is split into `2**BANK_BITS` banks. Word address `a` is stored in bank `a mod NB` at row `a / NB`, where NB is the number of banks. So a run of consecutive words spreads across every bank. A block read names one row. That row goes to all banks on the same clock edge. Each bank spends `LAT` cycles on the access, and then the whole row is copied into a set of output data registers. From there the words leave one per cycle, in ascending bank order, with a valid strobe.

The banks become free again once their access time has passed. The next row access can therefore start while the current row is still being shifted out. If a new block request arrives at the earliest cycle it is accepted, the output stream has no idle cycle between blocks.

Writes are collected one word per cycle into a staging buffer. When the buffer holds a full row, all banks are written together in a single bank cycle. A full buffer is written before any waiting read is accepted, so a later read of that row returns the new data.

Top module: `ilv_mem`

## Requirements
- R1: After a synchronous reset, `out_valid` is 0, `rd_ready` is 1 and `wr_ready` is 1.
- R2: A block read of row `b` returns the words at addresses `b*NB+0` up to `b*NB+NB-1`, in that order. Word `k` comes from bank `k`, and `out_bank` equals `k` while that word is valid.
- R3: Suppose a read is accepted on the clock edge where `rd_req` and `rd_ready` are both 1. Its first word is valid in the cycle that begins `LAT+2` edges after that edge, counting the accepting edge as the first. The remaining words follow on consecutive cycles with no gap.
- R4: After any bank access (a read or a row write), `rd_ready` stays 0 for `NB-1` cycles and then returns to 1 if no row write is pending. The parameters must satisfy `NB >= LAT`, and this is enforced at elaboration.
- R5: Reads issued at the earliest accepted cycles produce one unbroken output stream across block boundaries.
- R6: While `wr_ready` is 1, each cycle with `wr_en` stages one word. The k-th staged word goes to bank k. The `wr_row` presented with the NB-th word selects the row, and that row is written in all banks in one bank cycle.
- R7: While a full row is staged and not yet written, `wr_ready` is 0 and `wr_en` is ignored. The staged row is stored unchanged, and the next staged word again goes to bank 0.
- R8: A staged full row is written before a read is accepted: `rd_ready` is 0 while the row is pending. A read accepted before the row write returns the old data, and a read accepted after it returns the new data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_req | input | 1 | Block read request |
| rd_row | input | ROW_BITS | Row (upper address bits) of the block to read |
| rd_ready | output | 1 | A read request is accepted in this cycle |
| wr_en | input | 1 | Stage one write word |
| wr_row | input | ROW_BITS | Row for the staged block, taken with the last word |
| wr_data | input | DATA_W | Write word |
| wr_ready | output | 1 | Staging buffer can take a word |
| out_valid | output | 1 | Output word is valid |
| out_bank | output | BANK_BITS | Bank index (low address bits) of the output word |
| out_data | output | DATA_W | Output word |

## Verification
Each output word is compared with a bench model, and each word is also checked against the exact cycle it is expected in. The output registers show the contents of the output data registers directly. A wrong bank address, a stale output register or a wrong stream index therefore appears as a data or `out_bank` mismatch in the same block. A wrong bank-cycle counter or arrival pipeline shifts `rd_ready` or the first output word by at least one cycle. That shift is caught on the very next read, either by the timestamp comparison or by a gap in the back-to-back stream. An error in the write staging shows up as corrupted data on the first read of the affected row.

// File: rtl/ilv_mem_pkg.sv
package ilv_mem_pkg;
  typedef enum logic [1:0] {
    BANK_IDLE  = 2'd0,
    BANK_READ  = 2'd1,
    BANK_WRITE = 2'd2
  } bank_op_e;
endpackage

// File: rtl/ilv_bank.sv
module ilv_bank #(
  parameter int ROW_BITS = 4,
  parameter int DATA_W   = 8,
  parameter int LAT      = 3
) (
  input  logic                clk,
  input  logic                wr,
  input  logic                rd,
  input  logic [ROW_BITS-1:0] row,
  input  logic [DATA_W-1:0]   wdata,
  output logic [DATA_W-1:0]   rdata
);
  localparam int DEPTH = 1 << ROW_BITS;

  logic [DATA_W-1:0] mem   [DEPTH];
  logic [DATA_W-1:0] stage [LAT];

  // One access per cycle; the read result then walks LAT-1 delay stages,
  // so it appears LAT edges after the access.
  always_ff @(posedge clk) begin
    if (wr) mem[row] <= wdata;
    if (rd) stage[0] <= mem[row];
    for (int s = 1; s < LAT; s++) stage[s] <= stage[s-1];
  end

  assign rdata = stage[LAT-1];
endmodule

// File: rtl/ilv_wbuf.sv
module ilv_wbuf #(
  parameter int BANK_BITS = 2,
  parameter int ROW_BITS  = 4,
  parameter int DATA_W    = 8
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          wr_en,
  input  logic [DATA_W-1:0]             wr_data,
  input  logic [ROW_BITS-1:0]           wr_row,
  input  logic                          commit,
  output logic                          full,
  output logic [ROW_BITS-1:0]           row_q,
  output logic [(DATA_W<<BANK_BITS)-1:0] data_flat
);
  localparam int NB = 1 << BANK_BITS;

  logic [BANK_BITS-1:0] slot;
  logic [DATA_W-1:0]    words [NB];
  logic                 take;

  assign take = wr_en && !full;

  always_ff @(posedge clk) begin
    if (rst) begin
      slot <= '0;
      full <= 1'b0;
    end else if (commit) begin
      full <= 1'b0;
    end else if (take) begin
      if (slot == BANK_BITS'(NB-1)) begin
        full <= 1'b1;
        slot <= '0;
      end else begin
        slot <= slot + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (take) begin
      words[slot] <= wr_data;
      if (slot == BANK_BITS'(NB-1)) row_q <= wr_row;
    end
  end

  for (genvar b = 0; b < NB; b++) begin : g_flat
    assign data_flat[b*DATA_W +: DATA_W] = words[b];
  end
endmodule

// File: rtl/ilv_ctrl.sv
module ilv_ctrl
  import ilv_mem_pkg::*;
#(
  parameter int NB  = 4,
  parameter int LAT = 3
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     rd_req,
  input  logic     buf_full,
  output logic     rd_ready,
  output bank_op_e op,
  output logic     arrive
);
  localparam int GW = $clog2(NB + 1);

  logic [GW-1:0]  gap;
  logic [LAT-1:0] vpipe;

  assign rd_ready = (gap == '0) && !buf_full;
  assign arrive   = vpipe[LAT-1];

  // A pending row write wins the bank slot over a read.
  always_comb begin
    if (gap != '0)     op = BANK_IDLE;
    else if (buf_full) op = BANK_WRITE;
    else if (rd_req)   op = BANK_READ;
    else               op = BANK_IDLE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      gap   <= '0;
      vpipe <= '0;
    end else begin
      if (op != BANK_IDLE) gap <= GW'(NB-1);
      else if (gap != '0)  gap <= gap - 1'b1;
      vpipe <= (vpipe << 1) | LAT'(op == BANK_READ);
    end
  end
endmodule

// File: rtl/ilv_stream.sv
module ilv_stream #(
  parameter int BANK_BITS = 2,
  parameter int DATA_W    = 8
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           arrive,
  input  logic [(DATA_W<<BANK_BITS)-1:0] bank_data,
  output logic                           out_valid,
  output logic [BANK_BITS-1:0]           out_bank,
  output logic [DATA_W-1:0]              out_data
);
  localparam int NB = 1 << BANK_BITS;

  logic [(DATA_W<<BANK_BITS)-1:0] mdr;
  logic                           act;
  logic [BANK_BITS-1:0]           idx;

  always_ff @(posedge clk) begin
    if (rst) begin
      act       <= 1'b0;
      idx       <= '0;
      out_valid <= 1'b0;
    end else begin
      out_valid <= act;
      if (act) begin
        idx <= idx + 1'b1;
        if (idx == BANK_BITS'(NB-1)) act <= 1'b0;
      end
      // A new row may land on the edge that sends the last word.
      if (arrive) begin
        act <= 1'b1;
        idx <= '0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (arrive) mdr <= bank_data;
    if (act) begin
      out_data <= mdr[idx*DATA_W +: DATA_W];
      out_bank <= idx;
    end
  end
endmodule

// File: rtl/ilv_mem.sv
module ilv_mem
  import ilv_mem_pkg::*;
#(
  parameter int BANK_BITS = 2,
  parameter int ROW_BITS  = 4,
  parameter int DATA_W    = 8,
  parameter int LAT       = 3
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 rd_req,
  input  logic [ROW_BITS-1:0]  rd_row,
  output logic                 rd_ready,
  input  logic                 wr_en,
  input  logic [ROW_BITS-1:0]  wr_row,
  input  logic [DATA_W-1:0]    wr_data,
  output logic                 wr_ready,
  output logic                 out_valid,
  output logic [BANK_BITS-1:0] out_bank,
  output logic [DATA_W-1:0]    out_data
);
  localparam int NB     = 1 << BANK_BITS;
  localparam int FLAT_W = NB * DATA_W;

  bank_op_e            op;
  logic                arrive;
  logic                wb_full;
  logic [ROW_BITS-1:0] wb_row;
  logic [ROW_BITS-1:0] bank_row;
  logic [FLAT_W-1:0]   wb_data;
  logic [FLAT_W-1:0]   bank_q;

  assign wr_ready = !wb_full;
  assign bank_row = (op == BANK_WRITE) ? wb_row : rd_row;

  ilv_ctrl #(.NB(NB), .LAT(LAT)) u_ctrl (
    .clk(clk), .rst(rst), .rd_req(rd_req), .buf_full(wb_full),
    .rd_ready(rd_ready), .op(op), .arrive(arrive)
  );

  ilv_wbuf #(.BANK_BITS(BANK_BITS), .ROW_BITS(ROW_BITS), .DATA_W(DATA_W)) u_wbuf (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .wr_row(wr_row),
    .commit(op == BANK_WRITE), .full(wb_full), .row_q(wb_row), .data_flat(wb_data)
  );

  for (genvar b = 0; b < NB; b++) begin : g_bank
    ilv_bank #(.ROW_BITS(ROW_BITS), .DATA_W(DATA_W), .LAT(LAT)) u_bank (
      .clk(clk), .wr(op == BANK_WRITE), .rd(op == BANK_READ), .row(bank_row),
      .wdata(wb_data[b*DATA_W +: DATA_W]), .rdata(bank_q[b*DATA_W +: DATA_W])
    );
  end

  ilv_stream #(.BANK_BITS(BANK_BITS), .DATA_W(DATA_W)) u_stream (
    .clk(clk), .rst(rst), .arrive(arrive), .bank_data(bank_q),
    .out_valid(out_valid), .out_bank(out_bank), .out_data(out_data)
  );
endmodule

// File: rtl/ilv_mem_chk.sv
module ilv_mem_chk #(
  parameter int BANK_BITS = 2,
  parameter int LAT       = 3
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 rd_req,
  input logic                 rd_ready,
  input logic                 wr_ready,
  input logic                 out_valid,
  input logic [BANK_BITS-1:0] out_bank
);
  localparam int NB = 1 << BANK_BITS;

  // R4: configuration rule, rejected at elaboration
  if (NB < LAT) begin : g_bad_cfg
    $error("bank count below bank latency");
  end

  p_reset_state_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!out_valid && wr_ready));

  p_bank_step_r2: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_bank != '0) |-> ($past(out_valid) && $past(out_bank) == out_bank - 1'b1));

  p_no_gap_r3: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_bank != BANK_BITS'(NB-1)) |=> out_valid);

  if (NB > 1) begin : g_gap
    p_issue_gap_r4: assert property (@(posedge clk) disable iff (rst)
      (rd_req && rd_ready) |=> !rd_ready);
  end

  p_write_first_r8: assert property (@(posedge clk) disable iff (rst)
    rd_ready |-> wr_ready);
endmodule

bind ilv_mem ilv_mem_chk #(.BANK_BITS(BANK_BITS), .LAT(LAT)) u_chk (
  .clk(clk), .rst(rst), .rd_req(rd_req), .rd_ready(rd_ready),
  .wr_ready(wr_ready), .out_valid(out_valid), .out_bank(out_bank)
);

// File: tb/ilv_mem_bench.sv
module ilv_mem_bench;
  localparam int BB  = 2;
  localparam int RB  = 4;
  localparam int DW  = 8;
  localparam int LAT = 3;
  localparam int NB  = 1 << BB;
  localparam int NR  = 1 << RB;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          rd_req = 1'b0;
  logic [RB-1:0] rd_row = '0;
  logic          rd_ready;
  logic          wr_en = 1'b0;
  logic [RB-1:0] wr_row = '0;
  logic [DW-1:0] wr_data = '0;
  logic          wr_ready;
  logic          out_valid;
  logic [BB-1:0] out_bank;
  logic [DW-1:0] out_data;

  ilv_mem #(.BANK_BITS(BB), .ROW_BITS(RB), .DATA_W(DW), .LAT(LAT)) u_ilv_mem (
    .clk(clk), .rst(rst), .rd_req(rd_req), .rd_row(rd_row), .rd_ready(rd_ready),
    .wr_en(wr_en), .wr_row(wr_row), .wr_data(wr_data), .wr_ready(wr_ready),
    .out_valid(out_valid), .out_bank(out_bank), .out_data(out_data)
  );

  always #2 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit done   = 0;

  logic [DW-1:0] model [NR*NB];
  logic [DW-1:0] pend  [NB];
  int            wslot = 0;

  logic [DW-1:0] e_data [256];
  logic [BB-1:0] e_bank [256];
  int            e_cyc  [256];
  logic [7:0]    wp = '0;
  logic [7:0]    rp = '0;

  function automatic int addr_of(input int row, input int bank);
    return row * NB + bank;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cyc);
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000 && !done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      summary();
    end
  end

  // Output monitor: data (R2), bank order (R2), arrival cycle (R3)
  always @(negedge clk) begin
    if (!rst) begin
      if (out_valid) begin
        if (rp == wp) begin
          chk(1'b0, "R2 unexpected word", int'(out_data), -1);
        end else begin
          chk(out_data == e_data[rp], "R2 data", int'(out_data), int'(e_data[rp]));
          chk(out_bank == e_bank[rp], "R2 bank order", int'(out_bank), int'(e_bank[rp]));
          chk(cyc == e_cyc[rp], "R3 word cycle", cyc, e_cyc[rp]);
          rp <= rp + 1'b1;
        end
      end else if (rp != wp && cyc >= e_cyc[rp]) begin
        chk(1'b0, "R3 missing word", cyc, e_cyc[rp]);
        rp <= rp + 1'b1;
      end
    end
  end

  task automatic rd_block(input int row);
    while (!rd_ready) @(negedge clk);
    rd_req = 1'b1;
    rd_row = RB'(row);
    for (int k = 0; k < NB; k++) begin
      e_data[wp] = model[addr_of(row, k)];
      e_bank[wp] = BB'(k);
      e_cyc[wp]  = cyc + LAT + 2 + k;
      wp = wp + 1'b1;
    end
    @(negedge clk);
    rd_req = 1'b0;
  endtask

  task automatic wr_word(input int row, input logic [DW-1:0] d);
    while (!wr_ready) @(negedge clk);
    wr_en   = 1'b1;
    wr_data = d;
    wr_row  = RB'(row);
    @(negedge clk);
    wr_en = 1'b0;
    pend[wslot] = d;
    if (wslot == NB-1) begin
      for (int k = 0; k < NB; k++) model[addr_of(row, k)] = pend[k];
      wslot = 0;
    end else begin
      wslot++;
    end
  endtask

  task automatic wr_block(input int row);
    for (int k = 0; k < NB; k++) wr_word(row, DW'($urandom));
  endtask

  task automatic drain();
    while (rp != wp) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'd20240607));
    repeat (4) @(negedge clk);
    // R1: reset state
    chk(out_valid == 1'b0, "R1 out_valid", int'(out_valid), 0);
    chk(rd_ready == 1'b1, "R1 rd_ready", int'(rd_ready), 1);
    chk(wr_ready == 1'b1, "R1 wr_ready", int'(wr_ready), 1);
    rst = 1'b0;
    @(negedge clk);
    chk(out_valid == 1'b0 && rd_ready && wr_ready, "R1 after release", int'(out_valid), 0);

    // R6: fill every row with address-derived words
    for (int r = 0; r < NR; r++)
      for (int k = 0; k < NB; k++) wr_word(r, DW'(addr_of(r, k) * 3 + 1));
    // R2: sweep reads
    for (int r = 0; r < NR; r++) rd_block(r);
    drain();

    // R4: ready spacing after an accepted read
    rd_block(7);
    for (int k = 1; k < NB; k++) begin
      chk(rd_ready == 1'b0, "R4 ready low", int'(rd_ready), 0);
      @(negedge clk);
    end
    chk(rd_ready == 1'b1, "R4 ready back", int'(rd_ready), 1);
    drain();

    // R5: three back-to-back blocks form one unbroken stream
    fork
      begin
        rd_block(1); rd_block(9); rd_block(14);
      end
      begin
        repeat (LAT + 2) @(negedge clk);
        for (int i = 0; i < 3 * NB; i++) begin
          chk(out_valid == 1'b1, "R5 continuous stream", int'(out_valid), 1);
          @(negedge clk);
        end
      end
    join
    drain();

    // R8 and R7: row write pending behind a read, extra words ignored
    for (int k = 0; k < NB - 1; k++) wr_word(5, DW'(8'hA0 + k));
    rd_block(5);                       // old contents of row 5
    wr_word(5, DW'(8'hA0 + NB - 1));   // completes the row
    chk(rd_ready == 1'b0, "R8 read held while row pending", int'(rd_ready), 0);
    chk(wr_ready == 1'b0, "R7 staging full", int'(wr_ready), 0);
    while (!wr_ready) begin
      wr_en   = 1'b1;
      wr_data = 8'h5C;
      wr_row  = RB'(2);
      @(negedge clk);
    end
    wr_en = 1'b0;
    rd_block(5);                       // R8: new contents
    rd_block(2);                       // R7: row 2 untouched by ignored words
    wr_block(6);                       // R7: staging restarts at bank 0
    rd_block(6);
    drain();

    // Constrained random mix
    for (int i = 0; i < 300; i++) begin
      int sel;
      sel = int'($urandom % 8);
      if (sel < 4)      rd_block(int'($urandom % NR));
      else if (sel < 7) wr_block(int'($urandom % NR));
      else              repeat (int'($urandom % 5)) @(negedge clk);
    end
    drain();

    // Corner rows: lowest and highest block addresses
    wr_block(0);
    wr_block(NR - 1);
    rd_block(NR - 1);
    rd_block(0);
    drain();

    done = 1;
    summary();
  end
endmodule